// File: doc/BRIEF.md
# Compressor-Tree Unsigned Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (8 by default) and returns a product of twice that width. Each bit of the second operand gates a copy of the first operand through AND terms. The copy is shifted to that bit's weight, which gives one partial-product row per bit. Booth recoding is not used.

The rows are reduced in levels. Each level replaces every group of four rows with two rows, using a row of 4-2 compressor cells. Inside a compressor row, the cell at column k passes a horizontal carry to the cell at column k+1, and the lowest cell takes a constant zero. The two rows left after the last level go to a ripple adder built from full-adder cells.

The compressor cell is its own module and can be reused elsewhere. Its horizontal carry output depends only on its four primary inputs, so the horizontal chain never ripples through it.

Operands and product travel on valid/ready streams. With the output register enabled (the default), a transfer on the input side lands in the register on that clock edge. The product is then offered on the output side from the next cycle. A product that has not been taken is held unchanged for as long as the downstream side withholds ready. The input side is ready whenever the register is empty or is being drained in the same cycle, so a full-rate flow with no stalls is possible. With the register disabled, the block is purely combinational: valid passes forward and ready passes back.

Top module: `cmpr_tree_mult`

## Requirements
- R1: Every product offered with `prod_valid` high equals the unsigned product `opa * opb` of the operand pair accepted for it, for all operand pairs.
- R2: For all 32 combinations of the compressor cell inputs, x1+x2+x3+x4+cin = sum + 2*(carry+cout).
- R3: The compressor sum output is the exclusive-OR of x1, x2, x3, x4 and cin.
- R4: The compressor cout output does not change when only cin changes.
- R5: Compressor fixed rows: with three primary inputs high and cin=0, cout=1, carry=0, sum=1. With four high and cin=0, cout=1, carry=1, sum=0. With one high and cin=1, cout=0, carry=1, sum=0. With three high and cin=1, cout=1, carry=1, sum=0.
- R6: A cycle with `op_valid` and `op_ready` both high makes `prod_valid` high in the next cycle.
- R7: While `prod_valid` is high and `prod_ready` is low, `prod_valid` stays high and `product` stays unchanged in the next cycle.
- R8: `op_ready` is high whenever `prod_valid` is low or `prod_ready` is high, and low otherwise.
- R9: During and right after reset, `prod_valid` is low.
- R10: When the output is empty or drained and no operand pair is accepted, `prod_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opa | input | WIDTH | Multiplicand, unsigned |
| opb | input | WIDTH | Multiplier, unsigned |
| op_valid | input | 1 | Operand pair present |
| op_ready | output | 1 | Block can take the operand pair |
| product | output | 2*WIDTH | Unsigned product |
| prod_valid | output | 1 | Product present |
| prod_ready | input | 1 | Downstream takes the product |

## Verification
On every clock, the assertions check the stream rules: an acceptance leads to valid output, a stalled output holds steady, ready follows the rule in R8, and an idle cycle empties the output. They also compare each offered product against a multiply of the captured operands. The compressor cell's arithmetic identity, its fixed truth-table rows and the independence of cout from cin can only be shown by the bench, which drives a standalone cell through all 32 input combinations. Full operand coverage also comes only from the bench. It streams all 65536 pairs through the multiplier under a stall pattern and adds occasional idle gaps.

// File: rtl/cmpr_pkg.sv
package cmpr_pkg;
  localparam int unsigned DEF_WIDTH = 8;

  typedef struct packed {
    logic cout;
    logic carry;
    logic sum;
  } cell_out_t;
endpackage

// File: rtl/cmpr_fa.sv
module cmpr_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  always_comb begin
    s = x ^ y ^ z;
    c = (x & y) | (x & z) | (y & z);
  end
endmodule

// File: rtl/cmpr_cell42.sv
module cmpr_cell42
  import cmpr_pkg::*;
(
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic x4,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout
);
  logic      mid_s;
  cell_out_t res;

  // First adder sees only primary inputs, so cout is free of cin.
  cmpr_fa u_fa_hi (.x(x1), .y(x2), .z(x3), .s(mid_s), .c(res.cout));
  // Second adder folds in x4 and the horizontal carry.
  cmpr_fa u_fa_lo (.x(mid_s), .y(x4), .z(cin), .s(res.sum), .c(res.carry));

  always_comb begin
    sum   = res.sum;
    carry = res.carry;
    cout  = res.cout;
  end
endmodule

// File: rtl/cmpr_row42.sv
module cmpr_row42 #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] ra,
  input  logic [PW-1:0] rb,
  input  logic [PW-1:0] rc,
  input  logic [PW-1:0] rd,
  output logic [PW-1:0] srow,
  output logic [PW-1:0] crow
);
  // Horizontal chain: hz[k] enters column k; column 0 gets zero.
  logic [PW-1:0] hz;
  assign hz[0]   = 1'b0;
  assign crow[0] = 1'b0;

  for (genvar k = 0; k < PW - 1; k++) begin : g_col
    cmpr_cell42 u_cell (
      .x1   (ra[k]),
      .x2   (rb[k]),
      .x3   (rc[k]),
      .x4   (rd[k]),
      .cin  (hz[k]),
      .sum  (srow[k]),
      .carry(crow[k+1]),
      .cout (hz[k+1])
    );
  end

  // Top column: only the weight of this column fits in the product.
  assign srow[PW-1] = ra[PW-1] ^ rb[PW-1] ^ rc[PW-1] ^ rd[PW-1] ^ hz[PW-1];
endmodule

// File: rtl/cmpr_rca.sv
module cmpr_rca #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] xa,
  input  logic [PW-1:0] xb,
  output logic [PW-1:0] total
);
  logic [PW-1:0] rip;
  assign rip[0] = 1'b0;

  for (genvar k = 0; k < PW - 1; k++) begin : g_bit
    cmpr_fa u_fa (
      .x(xa[k]), .y(xb[k]), .z(rip[k]), .s(total[k]), .c(rip[k+1])
    );
  end

  assign total[PW-1] = xa[PW-1] ^ xb[PW-1] ^ rip[PW-1];
endmodule

// File: rtl/cmpr_tree_mult.sv
module cmpr_tree_mult
  import cmpr_pkg::*;
#(
  parameter int unsigned WIDTH   = DEF_WIDTH,  // power of two, at least 4
  parameter bit          REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  input  logic               op_valid,
  output logic               op_ready,
  output logic [2*WIDTH-1:0] product,
  output logic               prod_valid,
  input  logic               prod_ready
);
  localparam int unsigned PW     = 2 * WIDTH;
  localparam int unsigned LEVELS = $clog2(WIDTH) - 1;

  logic [PW-1:0] pp [WIDTH];
  logic [PW-1:0] comb_prod;

  // Partial products: AND terms shifted to the weight of each opb bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_pp
    assign pp[i] = PW'({WIDTH{opb[i]}} & opa) << i;
  end

  // Reduction levels: each halves the number of rows.
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int unsigned NR = WIDTH >> l;
    logic [PW-1:0] rows [NR];
    if (l == 0) begin : g_src
      for (genvar i = 0; i < NR; i++) begin : g_cp
        assign rows[i] = pp[i];
      end
    end else begin : g_red
      for (genvar g = 0; g < NR / 2; g++) begin : g_grp
        cmpr_row42 #(.PW(PW)) u_row (
          .ra  (g_lvl[l-1].rows[4*g]),
          .rb  (g_lvl[l-1].rows[4*g+1]),
          .rc  (g_lvl[l-1].rows[4*g+2]),
          .rd  (g_lvl[l-1].rows[4*g+3]),
          .srow(rows[2*g]),
          .crow(rows[2*g+1])
        );
      end
    end
  end

  cmpr_rca #(.PW(PW)) u_cpa (
    .xa   (g_lvl[LEVELS].rows[0]),
    .xb   (g_lvl[LEVELS].rows[1]),
    .total(comb_prod)
  );

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    logic          vld_q;
    logic          take;

    assign op_ready = !vld_q || prod_ready;
    assign take     = op_valid && op_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (op_ready) begin
        vld_q <= op_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (take) prod_q <= comb_prod;
    end

    assign product    = prod_q;
    assign prod_valid = vld_q;
  end else begin : g_comb
    assign op_ready   = prod_ready;
    assign prod_valid = op_valid;
    assign product    = comb_prod;
  end
endmodule

// File: rtl/cmpr_tree_mult_chk.sv
module cmpr_tree_mult_chk #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WIDTH-1:0]   opa,
  input logic [WIDTH-1:0]   opb,
  input logic               op_valid,
  input logic               op_ready,
  input logic [2*WIDTH-1:0] product,
  input logic               prod_valid,
  input logic               prod_ready
);
  if (REG_OUT) begin : g_chk
    logic [2*WIDTH-1:0] want;
    always_ff @(posedge clk) begin
      if (op_valid && op_ready) want <= (2*WIDTH)'(opa) * (2*WIDTH)'(opb);
    end

    AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      prod_valid |-> product == want); // R1
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready) |=> prod_valid); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_valid && !prod_ready) |=> (prod_valid && $stable(product))); // R7
    AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (!prod_valid || prod_ready) |-> op_ready); // R8
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ((!prod_valid || prod_ready) && !op_valid) |=> !prod_valid); // R10
  end
endmodule

bind cmpr_tree_mult cmpr_tree_mult_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op_valid(op_valid),
  .op_ready(op_ready), .product(product), .prod_valid(prod_valid),
  .prod_ready(prod_ready)
);

// File: tb/cmpr_tree_mult_bench.sv
`timescale 1ns/1ps
module cmpr_tree_mult_bench;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [W-1:0]   opa = '0, opb = '0;
  logic           op_valid = 1'b0, prod_ready = 1'b0;
  logic           op_ready, prod_valid;
  logic [2*W-1:0] product;

  logic x1 = 0, x2 = 0, x3 = 0, x4 = 0, cin = 0;
  logic c_sum, c_carry, c_cout;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit m_valid = 0;
  int m_prod  = 0;

  always #2.5 clk = ~clk;

  cmpr_tree_mult #(.WIDTH(W)) u_cmpr_tree_mult (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op_valid(op_valid),
    .op_ready(op_ready), .product(product), .prod_valid(prod_valid),
    .prod_ready(prod_ready)
  );

  cmpr_cell42 u_cell (
    .x1(x1), .x2(x2), .x3(x3), .x4(x4), .cin(cin),
    .sum(c_sum), .carry(c_carry), .cout(c_cout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Drive inputs now (at a negedge), advance one clock, compare at next negedge.
  task automatic step(input bit v, input int a, input int b, input bit rdy,
                      output bit accepted);
    op_valid = v; opa = W'(a); opb = W'(b); prod_ready = rdy;
    #1;
    check(op_ready == (!m_valid || rdy), "R8 op_ready", op_ready, (!m_valid || rdy));
    accepted = v && (!m_valid || rdy);
    if (!m_valid || rdy) begin
      m_valid = v;
      if (v) m_prod = a * b;
    end
    @(posedge clk); cyc++;
    @(negedge clk);
    check(prod_valid == m_valid, "R6/R7/R10 prod_valid", prod_valid, m_valid);
    if (m_valid) check(int'(product) == m_prod, "R1 product", product, m_prod);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit acc;
    // compressor cell: all 32 combinations
    for (int k = 0; k < 32; k++) begin
      int n, lhs, rhs;
      logic cout_alt;
      {cin, x4, x3, x2, x1} = 5'(k);
      #1;
      n = x1 + x2 + x3 + x4;
      lhs = n + cin;
      rhs = c_sum + 2 * (c_carry + c_cout);
      check(lhs == rhs, "R2 identity", rhs, lhs);
      check(c_sum == (lhs % 2), "R3 sum parity", c_sum, lhs % 2);
      cout_alt = c_cout;
      cin = ~cin; #1;
      check(c_cout == cout_alt, "R4 cout vs cin", c_cout, cout_alt);
      cin = ~cin; #1;
      if (n == 3 && cin == 0)
        check({c_cout, c_carry, c_sum} == 3'b101, "R5 three/cin0", {c_cout, c_carry, c_sum}, 5);
      if (n == 4 && cin == 0)
        check({c_cout, c_carry, c_sum} == 3'b110, "R5 four/cin0", {c_cout, c_carry, c_sum}, 6);
      if (n == 1 && cin == 1)
        check({c_cout, c_carry, c_sum} == 3'b010, "R5 one/cin1", {c_cout, c_carry, c_sum}, 2);
      if (n == 3 && cin == 1)
        check({c_cout, c_carry, c_sum} == 3'b110, "R5 three/cin1", {c_cout, c_carry, c_sum}, 6);
    end

    // reset
    repeat (3) @(negedge clk);
    check(prod_valid == 0, "R9 reset valid", prod_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(prod_valid == 0, "R9 after reset", prod_valid, 0);

    // corner pairs first, then all pairs with stalls and idle gaps
    step(1, 255, 255, 1, acc);
    step(1, 0, 200, 1, acc);
    step(1, 128, 2, 0, acc);
    step(0, 0, 0, 0, acc);
    step(0, 0, 0, 1, acc);
    step(0, 0, 0, 1, acc);
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        acc = 0;
        while (!acc) step(1, a, b, ((cyc % 7) != 3) && ((cyc % 11) != 5), acc);
        if (((a * 256 + b) % 97) == 0) step(0, 0, 0, 1, acc);
      end
    end
    step(0, 0, 0, 1, acc);
    step(0, 0, 0, 1, acc);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule